// File: doc/BRIEF.md
# Dual-Edge Pixel Word Demultiplexer

This block sits behind a 12-bit video input port on which every pixel is sent as two half-words. The first half-word (word A) is valid at a rising edge of the pixel clock, and the second (word B) is valid at the falling edge that follows. The block captures both half-words. It then pairs them and, using a 3-bit format select, scatters their bits into three 8-bit components. Horizontal sync, vertical sync and data-enable are captured with word A. They are delayed so that they leave on the same edge as the pixel they came with.

Three of the four packings carry RGB: a full 12+12 split, a 5-6-5 split and a 5-5-5 split. Components narrower than 8 bits are widened by copying their top bits into the vacant low bits. The fourth packing carries an 8-bit luma/chroma byte stream. In that stream, active-video start and end are marked by four-byte timing codes embedded in the data. In that mode the block tracks the active window from those codes rather than from the data-enable input. It shares each chroma pair across two luma samples and sends blanking levels outside the window. The block contains no logic that depends on the clock frequency, so it works at whatever pixel rate the mode needs.

Top module: `ddr_pixel_demux`

## Requirements
- R1: While reset is asserted, and until the first pixel is paired after release, all output components, px_hs, px_vs and px_de are 0.
- R2: A pixel whose word A is present at rising edge k and whose word B is present at the following falling edge appears on the outputs just after rising edge k+1. It appears together with the in_hs, in_vs and in_de values sampled at edge k.
- R3: Format code 0 (12+12 RGB): px_c0 = B[11:4], px_c1 = {B[3:0], A[11:8]} and px_c2 = A[7:0].
- R4: Format code 1 (5-6-5): red = B[11:7], green = {B[6:4], A[11:9]} and blue = A[8:4]. A 5-bit field x becomes {x, x[4:2]}, and a 6-bit field y becomes {y, y[5:4]}.
- R5: Format code 2 (5-5-5): red = B[10:6], green = {B[5:4], A[11:9]} and blue = A[8:4], each widened as in R4. B[11] has no effect.
- R6: In any RGB format, a pixel captured with in_de low comes out with all three components 0 and px_de low.
- R7: Format code 3 (luma/chroma bytes): each word carries one byte on bits [11:4], and bits [3:0] are ignored. The word B byte is luma (px_c0). The word A bytes of successive active pixels alternate Cb, Cr, Cb, Cr, starting with Cb after each start code. Every active pixel outputs the Cb and Cr bytes most recently received, counting its own, on px_c1 and px_c2. After reset both held chroma values are 128.
- R8: A pair whose bytes are A=FF and B=00, followed by a pair with A=00, forms a timing code, and the second pair's B byte is the flag byte. When flag bit 4 is 0, active video starts with the next pair. When it is 1, active video ends. Neither code pair is ever output as active.
- R9: In format code 3, px_de reflects only the tracked active window, and in_de has no effect. Outside the window the output is 16 on px_c0 and 128 on px_c1 and px_c2.
- R10: Unused format codes 4 to 7 unpack exactly like code 0.
- R11: px_hs and px_vs follow in_hs and in_vs with the R2 latency in every format, including format code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; both edges sample din |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_sel | input | 3 | Packing select, sampled with word A |
| din | input | 12 | Half-word data port |
| in_hs | input | 1 | Horizontal sync, sampled with word A |
| in_vs | input | 1 | Vertical sync, sampled with word A |
| in_de | input | 1 | Data-enable, sampled with word A |
| px_c0 | output | 8 | Red or luma |
| px_c1 | output | 8 | Green or Cb |
| px_c2 | output | 8 | Blue or Cr |
| px_hs | output | 1 | Aligned horizontal sync |
| px_vs | output | 1 | Aligned vertical sync |
| px_de | output | 1 | Aligned data-enable / active window |

## Verification
The assertions assume that word B is stable across the falling edge and word A across the rising edge. They also assume that, in byte mode, the FF,00 pattern appears only as the first half of a timing code, always starting on word A. The stimulus drives word A during the low half of each clock period and word B during the high half, so each word is settled a full nanosecond before the edge that samples it. The byte-mode sequences place every timing code on a pixel boundary and keep pixel bytes away from FF. The alignment checks assume that sync inputs are held low during reset.

// File: rtl/pxdmx_pkg.sv
`timescale 1ns/1ps
package pxdmx_pkg;
  localparam int WORD_W = 12;
  localparam int COMP_W = 8;
  localparam int BYTE_LSB = WORD_W - COMP_W;

  localparam logic [2:0] FMT_RGB24  = 3'd0;
  localparam logic [2:0] FMT_RGB565 = 3'd1;
  localparam logic [2:0] FMT_RGB555 = 3'd2;
  localparam logic [2:0] FMT_YCC8   = 3'd3;

  localparam logic [COMP_W-1:0] LUMA_BLANK   = 8'd16;
  localparam logic [COMP_W-1:0] CHROMA_BLANK = 8'd128;
  localparam logic [COMP_W-1:0] CODE_LEAD    = 8'hFF;
  localparam logic [COMP_W-1:0] CODE_ZERO    = 8'h00;
  localparam int FLAG_H_BIT = 4;

  typedef struct packed {
    logic [COMP_W-1:0] c0;
    logic [COMP_W-1:0] c1;
    logic [COMP_W-1:0] c2;
  } pix_t;

  function automatic logic [COMP_W-1:0] widen5(input logic [4:0] x);
    return {x, x[4:2]};
  endfunction

  function automatic logic [COMP_W-1:0] widen6(input logic [5:0] y);
    return {y, y[5:4]};
  endfunction
endpackage

// File: rtl/pxdmx_capture.sv
`timescale 1ns/1ps
module pxdmx_capture
  import pxdmx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_s,
  input  logic [W-1:0] din,
  input  logic [2:0]   fmt_sel,
  input  logic         in_hs,
  input  logic         in_vs,
  input  logic         in_de,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [2:0]   fmt_q,
  output logic         hs_q,
  output logic         vs_q,
  output logic         de_q
);
  // First half-word and its side-band signals on the rising edge.
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_q   <= '0;
      fmt_q <= FMT_RGB24;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      de_q  <= 1'b0;
    end else begin
      a_q   <= din;
      fmt_q <= fmt_sel;
      hs_q  <= in_hs;
      vs_q  <= in_vs;
      de_q  <= in_de;
    end
  end

  // Second half-word on the falling edge that follows.
  always_ff @(negedge clk or negedge rst_s) begin
    if (!rst_s) b_q <= '0;
    else        b_q <= din;
  end
endmodule

// File: rtl/pxdmx_unpack.sv
`timescale 1ns/1ps
module pxdmx_unpack
  import pxdmx_pkg::*;
(
  input  logic [2:0]        fmt,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output pix_t              pix
);
  localparam int NCOMP = 3;

  logic [NCOMP-1:0][5:0]        raw;
  logic [NCOMP-1:0]             is_six;
  logic [NCOMP-1:0][COMP_W-1:0] wide;
  logic                         narrow_fmt;

  always_comb begin
    if (fmt == FMT_RGB565) begin
      raw[0] = {1'b0, b[11:7]};
      raw[1] = {b[6:4], a[11:9]};
      raw[2] = {1'b0, a[8:4]};
      is_six = 3'b010;
    end else begin
      raw[0] = {1'b0, b[10:6]};
      raw[1] = {1'b0, b[5:4], a[11:9]};
      raw[2] = {1'b0, a[8:4]};
      is_six = 3'b000;
    end
  end

  for (genvar i = 0; i < NCOMP; i++) begin : g_widen
    assign wide[i] = is_six[i] ? widen6(raw[i]) : widen5(raw[i][4:0]);
  end

  assign narrow_fmt = (fmt == FMT_RGB565) || (fmt == FMT_RGB555);

  always_comb begin
    if (narrow_fmt) begin
      pix.c0 = wide[0];
      pix.c1 = wide[1];
      pix.c2 = wide[2];
    end else begin
      pix.c0 = b[11:4];
      pix.c1 = {b[3:0], a[11:8]};
      pix.c2 = a[7:0];
    end
  end
endmodule

// File: rtl/pxdmx_ycc_track.sv
`timescale 1ns/1ps
module pxdmx_ycc_track
  import pxdmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_s,
  input  logic              en,
  input  logic [COMP_W-1:0] a8,
  input  logic [COMP_W-1:0] b8,
  output logic [COMP_W-1:0] y_o,
  output logic [COMP_W-1:0] cb_o,
  output logic [COMP_W-1:0] cr_o,
  output logic              act_o
);
  logic              act_q, act_d;
  logic              phase_q, phase_d;
  logic              lead_q, lead_d;
  logic [COMP_W-1:0] cb_q, cb_d, cr_q, cr_d;
  logic              code_one, code_two, show;

  assign code_one = (a8 == CODE_LEAD) && (b8 == CODE_ZERO);
  assign code_two = lead_q && (a8 == CODE_ZERO);
  assign show     = act_q && !code_one && !code_two;

  always_comb begin
    act_d   = act_q;
    phase_d = phase_q;
    cb_d    = cb_q;
    cr_d    = cr_q;
    lead_d  = en && code_one;
    if (en) begin
      if (code_two) begin
        act_d   = ~b8[FLAG_H_BIT];
        phase_d = 1'b0;
      end
      if (show) begin
        phase_d = ~phase_q;
        if (!phase_q) cb_d = a8;
        else          cr_d = a8;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      act_q   <= 1'b0;
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      cb_q    <= CHROMA_BLANK;
      cr_q    <= CHROMA_BLANK;
    end else begin
      act_q   <= act_d;
      phase_q <= phase_d;
      lead_q  <= lead_d;
      cb_q    <= cb_d;
      cr_q    <= cr_d;
    end
  end

  assign act_o = show;
  assign y_o   = show ? b8 : LUMA_BLANK;
  assign cb_o  = show ? (phase_q ? cb_q : a8) : CHROMA_BLANK;
  assign cr_o  = show ? (phase_q ? a8 : cr_q) : CHROMA_BLANK;
endmodule

// File: rtl/ddr_pixel_demux.sv
`timescale 1ns/1ps
module ddr_pixel_demux
  import pxdmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fmt_sel,
  input  logic [WORD_W-1:0] din,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic              in_de,
  output logic [COMP_W-1:0] px_c0,
  output logic [COMP_W-1:0] px_c1,
  output logic [COMP_W-1:0] px_c2,
  output logic              px_hs,
  output logic              px_vs,
  output logic              px_de
);
  logic              rst_meta, rst_s;
  logic [WORD_W-1:0] a_q, b_q;
  logic [2:0]        fmt_q;
  logic              hs_q, vs_q, de_q;
  pix_t              rgb_pix, pix_d, pix_q;
  logic              de_d, is_ycc;
  logic [COMP_W-1:0] y_v, cb_v, cr_v;
  logic              y_act;

  // Reset: asserts at once, releases on the second rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  pxdmx_capture #(.W(WORD_W)) u_cap (
    .clk(clk), .rst_s(rst_s), .din(din), .fmt_sel(fmt_sel),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
    .a_q(a_q), .b_q(b_q), .fmt_q(fmt_q),
    .hs_q(hs_q), .vs_q(vs_q), .de_q(de_q)
  );

  pxdmx_unpack u_unp (
    .fmt(fmt_q), .a(a_q), .b(b_q), .pix(rgb_pix)
  );

  assign is_ycc = (fmt_q == FMT_YCC8);

  pxdmx_ycc_track u_ycc (
    .clk(clk), .rst_s(rst_s), .en(is_ycc),
    .a8(a_q[WORD_W-1:BYTE_LSB]), .b8(b_q[WORD_W-1:BYTE_LSB]),
    .y_o(y_v), .cb_o(cb_v), .cr_o(cr_v), .act_o(y_act)
  );

  always_comb begin
    if (is_ycc) begin
      pix_d = '{c0: y_v, c1: cb_v, c2: cr_v};
      de_d  = y_act;
    end else if (de_q) begin
      pix_d = rgb_pix;
      de_d  = 1'b1;
    end else begin
      pix_d = '0;
      de_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pix_q <= '0;
      px_de <= 1'b0;
      px_hs <= 1'b0;
      px_vs <= 1'b0;
    end else begin
      pix_q <= pix_d;
      px_de <= de_d;
      px_hs <= hs_q;
      px_vs <= vs_q;
    end
  end

  assign px_c0 = pix_q.c0;
  assign px_c1 = pix_q.c1;
  assign px_c2 = pix_q.c2;
endmodule

// File: rtl/ddr_pixel_demux_checker.sv
`timescale 1ns/1ps
module ddr_pixel_demux_checker (
  input logic        clk,
  input logic        rst_s,
  input logic [2:0]  fmt_q,
  input logic [11:0] a_q,
  input logic [11:0] b_q,
  input logic        de_q,
  input logic        in_hs,
  input logic        in_vs,
  input logic [7:0]  px_c0,
  input logic [7:0]  px_c1,
  input logic [7:0]  px_c2,
  input logic        px_hs,
  input logic        px_vs,
  input logic        px_de
);
  logic [1:0] since_rst;
  logic       ready;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)               since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end
  assign ready = (since_rst == 2'd2);

  // R2 R11: sync outputs trail the sampled inputs by two rising edges.
  assert_sync_align_R11: assert property (@(posedge clk) disable iff (!rst_s)
    ready |-> (px_hs == $past(in_hs, 2)) && (px_vs == $past(in_vs, 2)));

  // R6: RGB blanking drives zero components.
  assert_rgb_blank_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (ready && ($past(fmt_q) != 3'd3) && !px_de) |->
      (px_c0 == 8'd0) && (px_c1 == 8'd0) && (px_c2 == 8'd0));

  // R9: luma/chroma blanking levels outside the active window.
  assert_ycc_blank_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (ready && ($past(fmt_q) == 3'd3) && !px_de) |->
      (px_c0 == 8'd16) && (px_c1 == 8'd128) && (px_c2 == 8'd128));

  // R8: the leading pair of a timing code is never shown as active.
  assert_code_hidden_R8: assert property (@(posedge clk) disable iff (!rst_s)
    ((fmt_q == 3'd3) && (a_q[11:4] == 8'hFF) && (b_q[11:4] == 8'h00)) |=> !px_de);

  // R3: full-width split places the paired bits as specified.
  assert_rgb24_map_R3: assert property (@(posedge clk) disable iff (!rst_s)
    ((fmt_q == 3'd0) && de_q) |=>
      (px_c0 == $past(b_q[11:4])) &&
      (px_c1 == {$past(b_q[3:0]), $past(a_q[11:8])}) &&
      (px_c2 == $past(a_q[7:0])) && px_de);
endmodule

bind ddr_pixel_demux ddr_pixel_demux_checker u_chk (
  .clk(clk), .rst_s(rst_s), .fmt_q(fmt_q), .a_q(a_q), .b_q(b_q),
  .de_q(de_q), .in_hs(in_hs), .in_vs(in_vs),
  .px_c0(px_c0), .px_c1(px_c1), .px_c2(px_c2),
  .px_hs(px_hs), .px_vs(px_vs), .px_de(px_de)
);

// File: tb/ddr_pixel_demux_bench.sv
`timescale 1ns/1ps
module ddr_pixel_demux_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  fmt_sel;
  logic [11:0] din;
  logic        in_hs, in_vs, in_de;
  logic [7:0]  px_c0, px_c1, px_c2;
  logic        px_hs, px_vs, px_de;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ddr_pixel_demux u_ddr_pixel_demux (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .din(din),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
    .px_c0(px_c0), .px_c1(px_c1), .px_c2(px_c2),
    .px_hs(px_hs), .px_vs(px_vs), .px_de(px_de)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Independent byte-mode model state.
  bit       m_act, m_phase, m_lead;
  bit [7:0] m_cb, m_cr;

  bit [26:0] exp_q;
  string     exp_tag;
  bit        have_prev;

  function automatic bit [7:0] up5(input bit [4:0] x);
    return 8'((x * 8) + (x / 4));
  endfunction

  function automatic bit [7:0] up6(input bit [5:0] y);
    return 8'((y * 4) + (y / 16));
  endfunction

  task automatic check(input bit [26:0] got, input bit [26:0] want, input string tag);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic model(input bit [2:0] f, input bit [11:0] a, input bit [11:0] b,
                       input bit hs, input bit vs, input bit de);
    bit [7:0] r, g, bl;
    bit       d;
    bit [7:0] ab, bb;
    bit       c1, c2;
    ab = a[11:4];
    bb = b[11:4];
    if (f == 3'd3) begin
      c1 = (ab == 8'hFF) && (bb == 8'h00);
      c2 = m_lead && (ab == 8'h00);
      if (m_act && !c1 && !c2) begin
        if (!m_phase) m_cb = ab; else m_cr = ab;
        m_phase = !m_phase;
        r = bb; g = m_cb; bl = m_cr; d = 1;
      end else begin
        r = 8'd16; g = 8'd128; bl = 8'd128; d = 0;
      end
      if (c2) begin
        m_act = (bb[4] == 1'b0);
        m_phase = 0;
      end
      m_lead = c1;
      exp_tag = "R7 R8 R9";
    end else begin
      m_lead = 0;
      d = de;
      if (!de) begin
        r = 0; g = 0; bl = 0; exp_tag = "R6";
      end else if (f == 3'd1) begin
        r = up5(b[11:7]); g = up6({b[6:4], a[11:9]}); bl = up5(a[8:4]); exp_tag = "R4";
      end else if (f == 3'd2) begin
        r = up5(b[10:6]); g = up5({b[5:4], a[11:9]}); bl = up5(a[8:4]); exp_tag = "R5";
      end else begin
        r = b[11:4]; g = {b[3:0], a[11:8]}; bl = a[7:0];
        exp_tag = (f == 3'd0) ? "R3" : "R10";
      end
    end
    exp_q = {r, g, bl, hs, vs, d};
  endtask

  // One pixel: word A in the low half, word B in the high half.
  task automatic send(input bit [2:0] f, input bit [11:0] a, input bit [11:0] b,
                      input bit hs, input bit vs, input bit de);
    @(negedge clk); #1;
    din = a; fmt_sel = f; in_hs = hs; in_vs = vs; in_de = de;
    @(posedge clk); #1;
    if (have_prev)
      check({px_c0, px_c1, px_c2, px_hs, px_vs, px_de}, exp_q,
            $sformatf("%s (R2 R11 alignment)", exp_tag));
    din = b;
    model(f, a, b, hs, vs, de);
    have_prev = 1;
  endtask

  task automatic ypair(input bit [7:0] a8, input bit [7:0] b8, input bit de, input bit hs);
    send(3'd3, {a8, 4'hA}, {b8, 4'h5}, hs, 1'b0, de);
  endtask

  initial begin
    #700000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_act = 0; m_phase = 0; m_lead = 0; m_cb = 8'd128; m_cr = 8'd128;
    have_prev = 0;
    rst_n = 0; din = '0; fmt_sel = 3'd0; in_hs = 0; in_vs = 0; in_de = 0;
    repeat (3) @(posedge clk);
    #1;
    check({px_c0, px_c1, px_c2, px_hs, px_vs, px_de}, 27'd0, "R1 reset state");
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check({px_c0, px_c1, px_c2, px_hs, px_vs, px_de}, 27'd0, "R1 after release");

    // Sweeps of the three RGB packings.
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 256; i++)
        send(3'(f), 12'(i * 149 + 7 + f * 33), 12'(i * 2731 + 300),
             i[0], i[3], 1'b1);

    // Reserved codes act like the full split.
    for (int i = 0; i < 64; i++)
      send(3'(4 + (i % 4)), 12'(i * 613 + 11), 12'(i * 977 + 5), i[1], i[2], 1'b1);

    // RGB blanking with data-enable toggling.
    for (int i = 0; i < 64; i++)
      send(3'(i % 3), 12'(i * 389 + 1), 12'(i * 1201 + 9), i[2], i[4], i[0]);

    // Byte stream: blanking, start code, odd run, end code, blanking.
    for (int i = 0; i < 3; i++) ypair(8'd128, 8'd16, 1'b1, i[0]);
    ypair(8'hFF, 8'h00, 1'b1, 1'b0);
    ypair(8'h00, 8'h80, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) ypair(8'(40 + i * 17), 8'(60 + i * 23), i[0], i[1]);
    ypair(8'hFF, 8'h00, 1'b1, 1'b0);
    ypair(8'h00, 8'h9D, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) ypair(8'(200 + i), 8'(90 + i), 1'b1, 1'b1);
    // Second line: phase must restart on Cb after the odd run.
    ypair(8'hFF, 8'h00, 1'b0, 1'b0);
    ypair(8'h00, 8'hAB, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) ypair(8'(10 + i * 31), 8'(120 + i * 7), 1'b0, i[0]);
    ypair(8'hFF, 8'h00, 1'b0, 1'b0);
    ypair(8'h00, 8'hF1, 1'b0, 1'b0);
    ypair(8'h50, 8'h60, 1'b1, 1'b1);

    // Back to RGB, then flush the last byte-mode result.
    for (int i = 0; i < 4; i++)
      send(3'd0, 12'(i * 1111 + 3), 12'(i * 555 + 1), 1'b0, 1'b1, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule